// File: doc/BRIEF.md
# DRAM read burst output sequencer

This block models the memory side of a double-data-rate DRAM read path. It accepts read commands that carry a bank, a starting column, a burst-chop flag and an auto-precharge flag. After a programmable read latency it drives the data pins and the strobe: a one-clock strobe preamble, one data element on each clock edge, and then release of the pins. Data comes from a column-derived pattern rather than from an array. The two edges of a clock are shown as separate rising-edge and falling-edge lanes, and the strobe is shown as a two-bit pattern per clock, so the block remains synthesizable.

Read latency is the sum of the additive latency and the CAS latency. Both values are held in a small configuration register that stands in for a mode-register write. Commands enter on a valid/ready handshake. `cmd_ready` drops for the cycles that the minimum command spacing forbids, and the sender holds its command until the handshake completes. The output side has no back-pressure, as real DRAM pins cannot stall. A read issued at the minimum spacing after a full burst continues the data stream with no gap. A read issued at the same spacing after a chopped burst leaves a hole in the stream and gets a fresh preamble.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, `dq_oe`, `dqs_oe`, `dq_vld` and `pre_vld` are 0 and `cmd_ready` is 1. The latency register holds CL=5 and AL=0, so RL=5.
- R2: A command accepted on clock edge E (`cmd_valid` and `cmd_ready` both high) gives `dq_vld`=1 from edge E+RL onward, where RL=AL+CL. With CL=8 and AL=0 the first data is at edge E+8.
- R3: A pulse on `mr_wr` loads `mr_cl` and `mr_al` only if three conditions hold: 5 <= CL <= 11, AL < CL, and no read is in flight or being accepted. Any other write is ignored and the previous latency is kept.
- R4: In the j-th data clock of a burst that starts at column c, `dq_rise` = c+2j and `dq_fall` = c+2j+1. When `dq_vld` is 0, both lanes are 0.
- R5: In the clock before a burst's first data clock, `dq_oe`=1, `dqs_oe`=1, `dq_vld`=0 and `dqs_pat`=2'b00. This is the preamble, with the strobe low for both halves. In every data clock `dqs_pat`=2'b10, where bit 1 is the strobe level in the rising half and bit 0 is the level in the falling half.
- R6: If no further burst follows at once, `dq_oe` and `dqs_oe` drop in the clock after the last data clock. The falling half of that last clock is the postamble.
- R7: A command with `cmd_chop`=0 yields 4 data clocks (8 elements). A command with `cmd_chop`=1 yields 2 data clocks (4 elements).
- R8: After an accept, `cmd_ready` is 0 for 3 clocks, so the minimum command spacing is 4 clocks.
- R9: A full burst followed by another read at the minimum spacing gives a continuous stream. The second burst's first data clock directly follows the first burst's last data clock, with no preamble between them.
- R10: A chopped burst followed by another read at the minimum spacing gives 2 data clocks, then 1 clock with the pins released, then a preamble clock, then the next burst.
- R11: A burst with `cmd_ap`=1 pulses `pre_vld` for one clock, in the clock after its last data clock, with `pre_bank` equal to the command's bank. A burst with `cmd_ap`=0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_wr | input | 1 | Latency register write strobe |
| mr_cl | input | 4 | CAS latency to load |
| mr_al | input | 4 | Additive latency to load |
| cmd_valid | input | 1 | Read command present |
| cmd_ready | output | 1 | Command may be accepted this clock |
| cmd_bank | input | 3 | Bank of the read |
| cmd_col | input | 10 | Starting column |
| cmd_chop | input | 1 | 1 = chopped 4-element burst |
| cmd_ap | input | 1 | 1 = precharge the bank after the burst |
| dq_oe | output | 1 | Data pins driven |
| dq_vld | output | 1 | Lanes carry burst data this clock |
| dq_rise | output | 16 | Element driven in the rising half |
| dq_fall | output | 16 | Element driven in the falling half |
| dqs_oe | output | 1 | Strobe pins driven |
| dqs_pat | output | 2 | Strobe level for rising half (bit 1) and falling half (bit 0) |
| pre_vld | output | 1 | Auto-precharge pulse |
| pre_bank | output | 3 | Bank being precharged |

## Verification
Single full bursts are run at the reset latency and at CL=8/AL=0. The reset case confirms the default latency, and the CL=8/AL=0 case pins the first data edge, the element order and the strobe pattern. Three full bursts at minimum spacing test that the stream stays continuous with no stray preamble. Two chopped bursts at the same spacing must instead show the gap and the new preamble. A mix of chopped and full bursts at the largest and smallest latencies covers both ends of the token delay line. Illegal latency writes, and a legal write issued while a read is in flight, are each followed by a read whose data timing shows that the old latency was kept.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;
  parameter int unsigned COL_W  = 10;
  parameter int unsigned BANK_W = 3;
  parameter int unsigned LAT_W  = 4;
  parameter int unsigned RL_W   = LAT_W + 1;

  typedef struct packed {
    logic              v;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic              chop;
    logic              ap;
  } rd_tok_t;
endpackage

// File: rtl/dram_rd_cfg.sv
module dram_rd_cfg
  import dram_rd_pkg::*;
#(
  parameter int unsigned CL_MIN = 5,
  parameter int unsigned CL_MAX = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [LAT_W-1:0] cl_in,
  input  logic [LAT_W-1:0] al_in,
  input  logic            idle,
  output logic [RL_W-1:0] rl
);
  logic [LAT_W-1:0] cl_r, al_r;
  logic             legal;

  assign legal = (cl_in >= LAT_W'(CL_MIN)) && (cl_in <= LAT_W'(CL_MAX)) && (al_in < cl_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_r <= LAT_W'(CL_MIN);
      al_r <= '0;
    end else if (wr && legal && idle) begin
      cl_r <= cl_in;
      al_r <= al_in;
    end
  end

  assign rl = RL_W'(cl_r) + RL_W'(al_r);

  AST_LAT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(rl)); // R3
endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe
  import dram_rd_pkg::*;
#(
  parameter int unsigned TCCD  = 4,
  parameter int unsigned DEPTH = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  rd_tok_t         cmd_tok,
  input  logic [RL_W-1:0] rl,
  output rd_tok_t         head,
  output logic            nxt_v,
  output logic            busy
);
  localparam int unsigned GAP_W = $clog2(TCCD + 1);

  logic [GAP_W-1:0] gap;
  logic             acc;
  logic [RL_W-1:0]  wr_idx;
  rd_tok_t          slot [DEPTH];

  assign cmd_ready = (gap == '0);
  assign acc       = cmd_valid && cmd_ready;
  assign wr_idx    = rl - RL_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= '0;
    else if (acc)        gap <= GAP_W'(TCCD - 1);
    else if (gap != '0)  gap <= gap - GAP_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rd_tok_t up;
    if (i == DEPTH - 1) begin : g_top
      assign up = '0;
    end else begin : g_mid
      assign up = slot[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot[i] <= '0;
      else if (acc && wr_idx == RL_W'(i))  slot[i] <= cmd_tok;
      else                                 slot[i] <= up;
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) busy = busy | slot[i].v;
  end

  assign head  = slot[0];
  assign nxt_v = slot[1].v;

  AST_SPACING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !cmd_ready); // R8
endmodule

// File: rtl/dram_rd_burst.sv
module dram_rd_burst
  import dram_rd_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_tok_t           head,
  input  logic              nxt_v,
  output logic              dq_oe,
  output logic              dq_vld,
  output logic [DW-1:0]     dq_rise,
  output logic [DW-1:0]     dq_fall,
  output logic              dqs_oe,
  output logic [1:0]        dqs_pat,
  output logic              pre_vld,
  output logic [BANK_W-1:0] pre_bank,
  output logic              active
);
  logic              dvld, pre_r, ap_r, pv_r;
  logic [1:0]        rem;
  logic [2:0]        k;
  logic [COL_W-1:0]  colb;
  logic [BANK_W-1:0] bank_r, pb_r;
  logic              cont;

  assign cont = dvld && (rem != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvld   <= 1'b0;
      pre_r  <= 1'b0;
      rem    <= '0;
      k      <= '0;
      colb   <= '0;
      bank_r <= '0;
      ap_r   <= 1'b0;
      pv_r   <= 1'b0;
      pb_r   <= '0;
    end else begin
      if (head.v) begin
        dvld   <= 1'b1;
        rem    <= head.chop ? 2'd1 : 2'd3;
        k      <= '0;
        colb   <= head.col;
        bank_r <= head.bank;
        ap_r   <= head.ap;
      end else if (cont) begin
        rem <= rem - 2'd1;
        k   <= k + 3'd2;
      end else begin
        dvld <= 1'b0;
      end
      pre_r <= !(head.v || cont) && nxt_v;
      pv_r  <= dvld && (rem == 2'd0) && ap_r;
      pb_r  <= bank_r;
    end
  end

  assign dq_vld   = dvld;
  assign dq_oe    = dvld | pre_r;
  assign dqs_oe   = dvld | pre_r;
  assign dqs_pat  = dvld ? 2'b10 : 2'b00;
  assign dq_rise  = dvld ? (DW'(colb) + DW'(k)) : '0;
  assign dq_fall  = dvld ? (DW'(colb) + DW'(k) + DW'(1)) : '0;
  assign pre_vld  = pv_r;
  assign pre_bank = pb_r;
  assign active   = dvld | pre_r;

  AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    head.v |-> !cont); // R9
  AST_PREAMBLE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvld) |-> $past(pre_r)); // R5
  AST_PRECHG_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld |-> $past(dq_vld)); // R11
endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq
  import dram_rd_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned CL_MIN = 5,
  parameter int unsigned CL_MAX = 11,
  parameter int unsigned TCCD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr_wr,
  input  logic [LAT_W-1:0]  mr_cl,
  input  logic [LAT_W-1:0]  mr_al,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_chop,
  input  logic              cmd_ap,
  output logic              dq_oe,
  output logic              dq_vld,
  output logic [DW-1:0]     dq_rise,
  output logic [DW-1:0]     dq_fall,
  output logic              dqs_oe,
  output logic [1:0]        dqs_pat,
  output logic              pre_vld,
  output logic [BANK_W-1:0] pre_bank
);
  localparam int unsigned DEPTH = 2 * CL_MAX - 1;

  rd_tok_t         tok_in, head;
  logic [RL_W-1:0] rl;
  logic            nxt_v, busy, active, idle;

  assign tok_in = '{v: 1'b1, bank: cmd_bank, col: cmd_col, chop: cmd_chop, ap: cmd_ap};
  assign idle   = !busy && !active && !(cmd_valid && cmd_ready);

  dram_rd_cfg #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(mr_wr), .cl_in(mr_cl), .al_in(mr_al),
    .idle(idle), .rl(rl)
  );

  dram_rd_pipe #(.TCCD(TCCD), .DEPTH(DEPTH)) i_pipe (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_tok(tok_in), .rl(rl), .head(head), .nxt_v(nxt_v), .busy(busy)
  );

  dram_rd_burst #(.DW(DW)) i_burst (
    .clk(clk), .rst_n(rst_n), .head(head), .nxt_v(nxt_v),
    .dq_oe(dq_oe), .dq_vld(dq_vld), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dqs_oe(dqs_oe), .dqs_pat(dqs_pat), .pre_vld(pre_vld), .pre_bank(pre_bank),
    .active(active)
  );

  AST_RELEASE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> $past(dq_vld)); // R6
endmodule

// File: tb/test_dram_rd_seq.sv
module test_dram_rd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        mr_wr = 0;
  logic [3:0]  mr_cl = 0, mr_al = 0;
  logic        cmd_valid = 0, cmd_chop = 0, cmd_ap = 0;
  logic [2:0]  cmd_bank = 0;
  logic [9:0]  cmd_col = 0;
  logic        cmd_ready, dq_oe, dq_vld, dqs_oe, pre_vld;
  logic [15:0] dq_rise, dq_fall;
  logic [1:0]  dqs_pat;
  logic [2:0]  pre_bank;

  typedef struct { int cyc; int r; int f; bit first; } beat_t;
  typedef struct { int cyc; int bank; } pch_t;
  beat_t bq[$];
  pch_t  pq[$];
  beat_t b;
  pch_t  p;

  int cyc = 0, n_chk = 0, n_bad = 0, rl_m = 5;
  bit mon_en = 0, prev_vld = 0, done = 0;

  dram_rd_seq i_dram_rd_seq (
    .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_cl(mr_cl), .mr_al(mr_al),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_chop(cmd_chop), .cmd_ap(cmd_ap),
    .dq_oe(dq_oe), .dq_vld(dq_vld), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dqs_oe(dqs_oe), .dqs_pat(dqs_pat), .pre_vld(pre_vld), .pre_bank(pre_bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic send(int col, int bank, bit chop, bit ap);
    int acc, n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_col = 10'(col); cmd_bank = 3'(bank); cmd_chop = chop; cmd_ap = ap;
    cmd_valid = 1;
    @(posedge clk); #1;
    acc = cyc;
    cmd_valid = 0;
    n = chop ? 2 : 4;
    for (int j = 0; j < n; j++)
      bq.push_back('{cyc: acc + rl_m + j, r: (col + 2*j) & 16'hFFFF,
                     f: (col + 2*j + 1) & 16'hFFFF, first: (j == 0)});
    if (ap) pq.push_back('{cyc: acc + rl_m + n, bank: bank});
    @(negedge clk);
    chk(cmd_ready == 0, "R8 ready low after accept", int'(cmd_ready), 0);
  endtask

  // R3: take=1 only for writes that are legal and issued while idle
  task automatic set_mr(int cl, int al, bit take);
    @(negedge clk);
    mr_cl = 4'(cl); mr_al = 4'(al); mr_wr = 1;
    @(posedge clk); #1;
    mr_wr = 0;
    if (take) rl_m = cl + al;
  endtask

  task automatic drain();
    while (bq.size() != 0 || pq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (dq_vld) begin
        if (bq.size() == 0) begin
          chk(0, "R7 unexpected data beat", int'(dq_rise), 0);
        end else begin
          b = bq.pop_front();
          chk(cyc == b.cyc, "R2 R3 R7 R9 R10 beat timing", cyc, b.cyc);
          chk(int'(dq_rise) == b.r, "R4 rising lane", int'(dq_rise), b.r);
          chk(int'(dq_fall) == b.f, "R4 falling lane", int'(dq_fall), b.f);
          chk(dqs_oe && dq_oe && dqs_pat == 2'b10, "R5 strobe in data",
              int'(dqs_pat), 2);
        end
      end else begin
        if (bq.size() != 0 && bq[0].cyc <= cyc) begin
          b = bq.pop_front();
          chk(0, "R2 missed beat", cyc, b.cyc);
        end
        if (dq_oe) begin
          chk(bq.size() != 0 && bq[0].cyc == cyc + 1 && bq[0].first,
              "R5 preamble placement", cyc + 1, bq.size() != 0 ? bq[0].cyc : -1);
          chk(dqs_oe && dqs_pat == 2'b00, "R5 preamble strobe", int'(dqs_pat), 0);
        end else if (prev_vld) begin
          chk(!dqs_oe && dq_rise == 0 && dq_fall == 0, "R6 release after burst",
              int'(dqs_oe), 0);
        end
      end
      if (pre_vld) begin
        if (pq.size() == 0) begin
          chk(0, "R11 unexpected precharge", int'(pre_bank), -1);
        end else begin
          p = pq.pop_front();
          chk(cyc == p.cyc, "R11 precharge timing", cyc, p.cyc);
          chk(int'(pre_bank) == p.bank, "R11 precharge bank", int'(pre_bank), p.bank);
        end
      end else if (pq.size() != 0 && pq[0].cyc <= cyc) begin
        p = pq.pop_front();
        chk(0, "R11 missed precharge", cyc, p.cyc);
      end
      prev_vld = dq_vld;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!dq_oe && !dqs_oe, "R1 pins released", int'({dq_oe, dqs_oe}), 0);
    chk(!dq_vld && !pre_vld, "R1 no data or precharge", int'({dq_vld, pre_vld}), 0);
    chk(cmd_ready == 1, "R1 ready", int'(cmd_ready), 1);
    mon_en = 1;

    send(16'h010, 1, 0, 0);              // R1 default RL=5, R7 full burst
    drain();
    set_mr(8, 0, 1);                     // R2 CL=8 AL=0
    send(16'h3F8, 2, 0, 1);              // R11
    drain();
    set_mr(12, 0, 0);                    // R3 CL out of range
    set_mr(6, 6, 0);                     // R3 AL not below CL
    send(16'h020, 3, 0, 0);
    drain();
    set_mr(7, 3, 1);                     // RL=10
    send(16'h100, 0, 0, 0);              // R9 three back to back
    send(16'h108, 4, 0, 1);
    send(16'h110, 5, 0, 0);
    drain();
    send(16'h200, 6, 0, 0);
    set_mr(11, 0, 0);                    // R3 ignored while busy
    drain();
    send(16'h208, 6, 0, 0);
    drain();
    send(16'h040, 1, 1, 0);              // R10 chopped pair
    send(16'h044, 7, 1, 1);
    drain();
    set_mr(11, 10, 1);                   // largest RL
    send(16'h300, 2, 1, 1);
    send(16'h304, 3, 0, 0);
    send(16'h30C, 4, 0, 1);
    drain();
    set_mr(5, 0, 1);                     // smallest RL
    send(16'h3FC, 0, 1, 0);
    send(16'h000, 1, 0, 1);
    drain();

    chk(bq.size() == 0 && pq.size() == 0, "R2 R11 all expected items seen",
        bq.size() + pq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule